// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns data words into serial frames on a single line that rests high between frames. A frame opens with one low start bit, carries 5 to 9 data bits with the least significant bit first, may add an even or odd parity bit, and closes with one or two high stop bits. Frame shape is chosen at run time through a length code, a parity enable, a parity sense select and a stop-count select.

Software-side logic writes a word into a one-entry holding register while the previous word is still being shifted out. When the line becomes free, the holding register moves into the shift register. A separate clock unit supplies a one-cycle `bit_tick` pulse for each bit period, so the same transmitter serves both asynchronous and clocked serial links. Two status levels are provided. `dre` means the holding register can take a new word. `txc` means the last frame has fully left the line and nothing else is queued.

The sequencer has six named states. IDLE moves to START on a tick when the holding register is full; this is the load transition. START moves to DATA on the next tick. DATA stays in DATA until the last configured data bit, then moves to PARITY when parity is enabled or to STOP1 when it is not. PARITY moves to STOP1. STOP1 moves to STOP2 when two stop bits are selected. When STOP1 or STOP2 is the final stop bit, it moves to START with a load if a word is waiting, and to IDLE otherwise; the move to IDLE is the frame-end transition and sets `txc`. No state changes without a tick.

Top module: `frame_tx_top`

## Requirements
- R1: After reset `tx_out` is 1, `dre` is 1 and `txc` is 0. The line stays 1 in IDLE.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then 1-valued stop bits. Each bit lasts from one `bit_tick` to the next, and the sequencer state never changes on a cycle without a tick.
- R3: `cfg_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits. Codes 5, 6 and 7 select 8 bits. Data bits 0 to 7 come from `wr_data[0..7]`, and the 9th data bit comes from `wr_bit8`.
- R4: With `cfg_par_en`=1, the parity bit is chosen so that the count of ones in the sent data bits plus the parity bit is even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1.
- R5: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two.
- R6: The frame configuration is captured on the load tick. Changing the configuration inputs while a frame is in flight has no effect on that frame.
- R7: `dre` drops in the cycle after a write is accepted. It rises again in the cycle after the load tick moves the word into the shift register.
- R8: A write while the holding register is full, on a cycle with no load, is dropped. The word already held is the one sent.
- R9: If a word is waiting when the final stop bit ends, that same tick starts the next frame's start bit, and `txc` stays 0.
- R10: `txc` sets when the final stop bit ends with the holding register empty. An accepted write clears `txc`, and while `txc` is 1, `dre` is 1.
- R11: Ticks in IDLE with an empty holding register leave the line at 1 and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the clock unit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data bits 0 to 7 |
| wr_bit8 | input | 1 | Ninth data bit, used in 9-bit mode |
| cfg_len | input | 3 | Data length code (0..4 select 5..9 bits; 5..7 select 8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| tx_out | output | 1 | Serial line, high when idle |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmission complete, nothing queued |

## Verification
The bench builds the block with the default `MAX_BITS` of 9. This makes the ninth-bit input path, the 9-bit length code and the fall-back of codes 5 to 7 to eight bits all reachable. The bench pulses `bit_tick` by hand, one clock wide, so each frame bit can be sampled right after the tick that starts it. That same control lets the bench place writes in exact positions: during a frame, on a full holding register, and between frames.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } ftx_state_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } ftx_cfg_t;

endpackage

// File: rtl/ftx_holding.sv
module ftx_holding #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              load,
    output logic              full,
    output logic              accepted,
    output logic [WORD_W-1:0] word
);

    logic              full_q;
    logic [WORD_W-1:0] word_q;

    // A write is taken when the slot is free or is being emptied this cycle.
    assign accepted = wr_en && (!full_q || load);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            word_q <= '0;
        end else begin
            full_q <= accepted || (full_q && !load);
            if (accepted) begin
                word_q <= wr_word;
            end
        end
    end

    assign full = full_q;
    assign word = word_q;

    assert_load_needs_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> full_q);

    assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_q) |=> full_q);

    assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full_q && !load) |=> $stable(word_q));

endmodule

// File: rtl/ftx_parity.sv
module ftx_parity #(
    parameter int WORD_W = 9,
    parameter int CNT_W  = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              odd,
    output logic              par
);

    logic [WORD_W-1:0] masked;

    // Only bits below the configured length take part in the parity.
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign masked[i] = word[i] && (CNT_W'(i) < nbits);
    end

    assign par = (^masked) ^ odd;

endmodule

// File: rtl/ftx_sequencer.sv
module ftx_sequencer
    import ftx_pkg::*;
#(
    parameter int WORD_W   = 9,
    parameter int MIN_BITS = 5,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    input  ftx_cfg_t          cfg,
    input  logic              clr_done,
    output logic              load,
    output logic              tx_out,
    output logic              done
);

    localparam int SPAN = WORD_W - MIN_BITS;

    ftx_state_e        st, nxt;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  nbits_q;
    logic [CNT_W-1:0]  nbits_live;
    logic              par_q, par_live;
    logic              par_en_q, two_stop_q;
    logic              frame_end;
    logic              done_q;

    function automatic logic [CNT_W-1:0] len_of(input logic [2:0] code);
        if (int'(code) <= SPAN) begin
            return CNT_W'(MIN_BITS + int'(code));
        end
        return CNT_W'(8);
    endfunction

    assign nbits_live = len_of(cfg.len_code);

    ftx_parity #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) u_parity (
        .word (hold_word),
        .nbits(nbits_live),
        .odd  (cfg.par_odd),
        .par  (par_live)
    );

    // Next-state and transition decode
    always_comb begin
        nxt       = st;
        load      = 1'b0;
        frame_end = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (bit_tick && hold_full) begin
                    nxt  = ST_START;
                    load = 1'b1;
                end
            end
            ST_START: begin
                if (bit_tick) begin
                    nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_tick && (cnt == nbits_q - CNT_W'(1))) begin
                    nxt = par_en_q ? ST_PARITY : ST_STOP1;
                end
            end
            ST_PARITY: begin
                if (bit_tick) begin
                    nxt = ST_STOP1;
                end
            end
            ST_STOP1: begin
                if (bit_tick) begin
                    if (two_stop_q) begin
                        nxt = ST_STOP2;
                    end else if (hold_full) begin
                        nxt  = ST_START;
                        load = 1'b1;
                    end else begin
                        nxt       = ST_IDLE;
                        frame_end = 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (bit_tick) begin
                    if (hold_full) begin
                        nxt  = ST_START;
                        load = 1'b1;
                    end else begin
                        nxt       = ST_IDLE;
                        frame_end = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            shreg      <= '0;
            cnt        <= '0;
            nbits_q    <= CNT_W'(8);
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            st <= nxt;
            if (load) begin
                shreg      <= hold_word;
                cnt        <= '0;
                nbits_q    <= nbits_live;
                par_q      <= par_live;
                par_en_q   <= cfg.par_en;
                two_stop_q <= cfg.two_stop;
            end else if (st == ST_DATA && bit_tick) begin
                shreg <= shreg >> 1;
                cnt   <= cnt + CNT_W'(1);
            end
            if (clr_done) begin
                done_q <= 1'b0;
            end else if (frame_end) begin
                done_q <= 1'b1;
            end
        end
    end

    // Line output
    always_comb begin
        unique case (st)
            ST_START:  tx_out = 1'b0;
            ST_DATA:   tx_out = shreg[0];
            ST_PARITY: tx_out = par_q;
            default:   tx_out = 1'b1;
        endcase
    end

    assign done = done_q;

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(st));

    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |-> (cnt < nbits_q));

    assert_done_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (st == ST_IDLE));

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !bit_tick) |=> tx_out);

endmodule

// File: rtl/frame_tx_top.sv
module frame_tx_top
    import ftx_pkg::*;
#(
    parameter int MAX_BITS = 9,
    parameter int MIN_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                wr_en,
    input  logic [MAX_BITS-2:0] wr_data,
    input  logic                wr_bit8,
    input  logic [2:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_two_stop,
    output logic                tx_out,
    output logic                dre,
    output logic                txc
);

    localparam int CNT_W = $clog2(MAX_BITS + 1);

    logic                full, accepted, load;
    logic [MAX_BITS-1:0] hold_word;
    ftx_cfg_t            cfg;

    assign cfg = '{len_code: cfg_len, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    ftx_holding #(
        .WORD_W(MAX_BITS)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word ({wr_bit8, wr_data}),
        .load    (load),
        .full    (full),
        .accepted(accepted),
        .word    (hold_word)
    );

    ftx_sequencer #(
        .WORD_W  (MAX_BITS),
        .MIN_BITS(MIN_BITS),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .hold_full(full),
        .hold_word(hold_word),
        .cfg      (cfg),
        .clr_done (accepted),
        .load     (load),
        .tx_out   (tx_out),
        .done     (txc)
    );

    assign dre = !full;

    assert_txc_implies_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txc |-> dre);

endmodule

// File: tb/tb_frame_tx_top.sv
module tb_frame_tx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_bit8 = 1'b0;
    logic [2:0] cfg_len = 3'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       tx_out, dre, txc;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    frame_tx_top dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_bit8(wr_bit8), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .tx_out(tx_out), .dre(dre), .txc(txc)
    );

    // {data9, len code, parity enable, odd select, two stop}
    localparam logic [14:0] VEC [8] = '{
        {9'h055, 3'd3, 1'b0, 1'b0, 1'b0},
        {9'h0A3, 3'd3, 1'b1, 1'b0, 1'b1},
        {9'h1C5, 3'd4, 1'b1, 1'b1, 1'b1},
        {9'h01F, 3'd0, 1'b1, 1'b0, 1'b0},
        {9'h0FF, 3'd1, 1'b1, 1'b1, 1'b1},
        {9'h02A, 3'd2, 1'b0, 1'b0, 1'b1},
        {9'h1FF, 3'd6, 1'b1, 1'b0, 1'b0},
        {9'h100, 3'd4, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frame bits, index 0 is the start bit
    task automatic model(input logic [8:0] d, input logic [2:0] code, input logic pe,
                         input logic po, input logic ts,
                         output logic [15:0] bits, output int len);
        int n;
        logic p;
        n = (code <= 3'd4) ? 5 + int'(code) : 8;
        bits = '1;
        bits[0] = 1'b0;
        p = po;
        for (int i = 0; i < n; i++) begin
            bits[1 + i] = d[i];
            p = p ^ d[i];
        end
        len = 1 + n;
        if (pe) begin
            bits[len] = p;
            len++;
        end
        len = len + (ts ? 2 : 1);
    endtask

    task automatic tick_once();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic write_word(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d[7:0];
        wr_bit8 = d[8];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] code, input logic pe, input logic po, input logic ts);
        cfg_len = code;
        cfg_par_en = pe;
        cfg_par_odd = po;
        cfg_two_stop = ts;
    endtask

    // Ticks through bits 1..len-1 of an already started frame
    task automatic walk_rest(input string req, input logic [15:0] bits, input int len);
        for (int i = 1; i < len; i++) begin
            tick_once();
            chk(req, 16'(tx_out), 16'(bits[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] bits;
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 line", 16'(tx_out), 16'd1);
        chk("R1 dre", 16'(dre), 16'd1);
        chk("R1 txc", 16'(txc), 16'd0);

        // R11 ticks with nothing queued
        tick_once();
        tick_once();
        chk("R11 idle line", 16'(tx_out), 16'd1);
        chk("R11 still empty", 16'(dre), 16'd1);

        // Table walk: R2 R3 R4 R5 R7 R10
        for (int v = 0; v < 8; v++) begin
            set_cfg(VEC[v][5:3], VEC[v][2], VEC[v][1], VEC[v][0]);
            model(VEC[v][14:6], VEC[v][5:3], VEC[v][2], VEC[v][1], VEC[v][0], bits, len);
            write_word(VEC[v][14:6]);
            chk("R7 dre low after write", 16'(dre), 16'd0);
            chk("R10 txc cleared by write", 16'(txc), 16'd0);
            tick_once();
            chk("R2 start bit", 16'(tx_out), 16'd0);
            chk("R7 dre high after load", 16'(dre), 16'd1);
            walk_rest("R2 R3 R4 R5 frame bit", bits, len);
            tick_once();
            chk("R10 txc at frame end", 16'(txc), 16'd1);
            chk("R1 line idle", 16'(tx_out), 16'd1);
        end

        // R6 configuration change mid-frame
        set_cfg(3'd0, 1'b0, 1'b0, 1'b0);
        model(9'h016, 3'd0, 1'b0, 1'b0, 1'b0, bits, len);
        write_word(9'h016);
        tick_once();
        set_cfg(3'd4, 1'b1, 1'b1, 1'b1);
        walk_rest("R6 latched cfg", bits, len);
        tick_once();
        chk("R6 frame length kept", 16'(txc), 16'd1);

        // R8 write on full holding register dropped
        set_cfg(3'd3, 1'b0, 1'b0, 1'b0);
        model(9'h00F, 3'd3, 1'b0, 1'b0, 1'b0, bits, len);
        write_word(9'h00F);
        write_word(9'h0F0);
        tick_once();
        chk("R8 start", 16'(tx_out), 16'd0);
        walk_rest("R8 held word sent", bits, len);
        tick_once();
        chk("R8 no second frame txc", 16'(txc), 16'd1);
        tick_once();
        chk("R8 R11 line stays high", 16'(tx_out), 16'd1);

        // R9 back-to-back frames
        model(9'h0C3, 3'd3, 1'b0, 1'b0, 1'b0, bits, len);
        write_word(9'h0C3);
        tick_once();
        write_word(9'h03C);
        chk("R7 dre low while queued", 16'(dre), 16'd0);
        walk_rest("R9 first frame", bits, len);
        tick_once();
        chk("R9 next start bit", 16'(tx_out), 16'd0);
        chk("R9 txc stays low", 16'(txc), 16'd0);
        chk("R9 dre after reload", 16'(dre), 16'd1);
        model(9'h03C, 3'd3, 1'b0, 1'b0, 1'b0, bits, len);
        walk_rest("R9 second frame", bits, len);
        tick_once();
        chk("R9 txc after last frame", 16'(txc), 16'd1);

        // R2 no advance without a tick
        write_word(9'h001);
        tick_once();
        repeat (5) @(negedge clk);
        chk("R2 start held without tick", 16'(tx_out), 16'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule